// File: doc/BRIEF.md
# Signed-Digit Coefficient Multiplier Bank

This block multiplies one signed sample by the four analysis coefficients of a two-tap-pair wavelet low-pass filter in a single pass. It produces all four products at once. It contains no multiplier. The input is widened with fractional guard bits. Five arithmetic right shifts of it form a shared set of terms. Four pre-summed pairs are built from those terms. Each product is then two more add/subtract steps on shifted copies of the pairs. The whole bank costs about a dozen adders. The coefficients are fixed in signed-digit form, so no two nonzero digits are adjacent.

The bank sits inside a polyphase filter element. The host feeds one sample per cycle and collects the four products. It then scales and accumulates them into the filter output. An optional register stage after rounding can be switched off, which leaves a purely combinational path. A second option selects between round-half-up and plain truncation when the guard bits are dropped.

Top module: `sd_coef_mult_bank`

## Requirements
- R1: `x_in` is a two's-complement signed word. The input value -2^(IN_W-1) yields exactly y0=4168, y1=-7768, y2=-28041, y3=-16105 in both output modes (IN_W=16).
- R2: With S = x·2^GRD and Ck = floor(S/2^(4-k)) for k=0..4, and with B0=C0+C3, B1=C1+C3, B2=C1-C3 and B3=C4-C1, the internal product P0 = -C1 - floor(B0/2^8), and y0 is P0 converted per R6.
- R3: P1 = C2 + floor(B2/2^5) - floor(B1/2^9), and y1 is P1 converted per R6, bit for bit.
- R4: P2 = B3 - floor(B1/2^5) + floor(B0/2^11), and y2 is P2 converted per R6, bit for bit.
- R5: P3 = C3 - floor(B0/2^6) + floor(B0/2^11), and y3 is P3 converted per R6, bit for bit.
- R6: With ROUND_OUT=1 each output is floor((P+2^(GRD-1))/2^GRD). With ROUND_OUT=0 it is floor(P/2^GRD). Outputs are IN_W+1 bits wide.
- R7: With REG_OUT=1 the outputs show the input sampled at the previous rising clock edge. An active-low asynchronous reset forces them to zero at once and holds them there. With REG_OUT=0 the outputs follow the input within the same cycle.
- R8: Let Kk be the realized constants -4168, 7768, 28041 and 16105, each divided by 32768. Each output lies within 1 LSB of x·Kk when rounding and within 2 LSB when truncating. Each output also lies within 0.021·|x|+2 of x times the nominal coefficient -0.1294, 0.2241, 0.8365 or 0.4830.
- R9: y0 is never of the same strict sign as x. y1, y2 and y3 are never of the opposite strict sign. A zero input gives four zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| x_in | input | IN_W | Signed input sample |
| y0_o | output | IN_W+1 | Signed product with the first coefficient (negative) |
| y1_o | output | IN_W+1 | Signed product with the second coefficient |
| y2_o | output | IN_W+1 | Signed product with the third coefficient |
| y3_o | output | IN_W+1 | Signed product with the fourth coefficient |

## Verification
The block holds no state apart from the optional output register. Any wrong shift distance, wrong pair sign or wrong rounding constant therefore shows up in the very next registered sample, or in the same cycle when REG_OUT=0. Such a fault usually shows as a constant gain error. It reaches several LSB at large inputs, so full-scale and random inputs expose it quickly, while small inputs often round it away. A swapped pair or a wrong shift in a shared term upsets more than one product at once. A latency or reset fault shows as a one-sample skew, or as a nonzero output while reset is held.

// File: rtl/sdmb_pkg.sv
package sdmb_pkg;
   // shared term count, pre-summed pair count, product count
   localparam int NUM_TERMS = 5;
   localparam int NUM_PAIRS = 4;
   localparam int NUM_PROD  = 4;
   // integer headroom bits above the input sign for pair sums up to 1.5x
   localparam int HEADROOM  = 2;
   // right shift applied to the widened input for term k
   localparam int TERM_SHIFT [NUM_TERMS] = '{4, 3, 2, 1, 0};
   // second-level shifts used by the product network
   localparam int SH_P0_B0  = 8;
   localparam int SH_P1_B2  = 5;
   localparam int SH_P1_B1  = 9;
   localparam int SH_P2_B1  = 5;
   localparam int SH_P23_B0 = 11;
   localparam int SH_P3_B0  = 6;
   // realized constants as numerators over 2^KDEN_LOG2
   localparam int KDEN_LOG2 = 15;
   localparam int KNUM [NUM_PROD] = '{-4168, 7768, 28041, 16105};
endpackage

// File: rtl/sdmb_shift_terms.sv
module sdmb_shift_terms
   import sdmb_pkg::*;
#(
   parameter int IW = 24
) (
   input  logic signed [IW-1:0] xe_i,
   output logic signed [IW-1:0] term_o [NUM_TERMS],
   output logic signed [IW-1:0] pair_o [NUM_PAIRS]
);
   for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
      assign term_o[g] = xe_i >>> TERM_SHIFT[g];
   end

   // pre-summed pairs shared by several products
   assign pair_o[0] = term_o[0] + term_o[3];
   assign pair_o[1] = term_o[1] + term_o[3];
   assign pair_o[2] = term_o[1] - term_o[3];
   assign pair_o[3] = term_o[4] - term_o[1];
endmodule

// File: rtl/sdmb_product_net.sv
module sdmb_product_net
   import sdmb_pkg::*;
#(
   parameter int IW = 24
) (
   input  logic signed [IW-1:0] term_i [NUM_TERMS],
   input  logic signed [IW-1:0] pair_i [NUM_PAIRS],
   output logic signed [IW-1:0] prod_o [NUM_PROD]
);
   logic signed [IW-1:0] b0_deep;

   // one shifted copy reused by two products
   assign b0_deep = pair_i[0] >>> SH_P23_B0;

   assign prod_o[0] = -term_i[1] - (pair_i[0] >>> SH_P0_B0);
   assign prod_o[1] = term_i[2] + (pair_i[2] >>> SH_P1_B2) - (pair_i[1] >>> SH_P1_B1);
   assign prod_o[2] = pair_i[3] - (pair_i[1] >>> SH_P2_B1) + b0_deep;
   assign prod_o[3] = term_i[3] - (pair_i[0] >>> SH_P3_B0) + b0_deep;
endmodule

// File: rtl/sdmb_out_stage.sv
module sdmb_out_stage
   import sdmb_pkg::*;
#(
   parameter int IW        = 24,
   parameter int OW        = 17,
   parameter int GRD       = 6,
   parameter bit ROUND_OUT = 1'b1,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic signed [IW-1:0] prod_i [NUM_PROD],
   output logic signed [OW-1:0] y_o    [NUM_PROD]
);
   localparam int HALF_I = ROUND_OUT ? (1 << (GRD - 1)) : 0;

   logic signed [OW-1:0] y_next [NUM_PROD];

   for (genvar g = 0; g < NUM_PROD; g++) begin : g_conv
      logic signed [IW-1:0] biased;
      logic signed [IW-1:0] scaled;
      assign biased    = prod_i[g] + IW'(HALF_I);
      assign scaled    = biased >>> GRD;
      assign y_next[g] = OW'(scaled);

      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) y_o[g] <= '0;
            else        y_o[g] <= y_next[g];
         end
      end else begin : g_comb
         assign y_o[g] = y_next[g];
      end
   end
endmodule

// File: rtl/sd_coef_mult_bank.sv
module sd_coef_mult_bank
   import sdmb_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter int GRD       = 6,
   parameter bit ROUND_OUT = 1'b1,
   parameter bit REG_OUT   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic signed [IN_W-1:0] x_in,
   output logic signed [IN_W:0]   y0_o,
   output logic signed [IN_W:0]   y1_o,
   output logic signed [IN_W:0]   y2_o,
   output logic signed [IN_W:0]   y3_o
);
   localparam int IW = HEADROOM + IN_W + GRD;
   localparam int OW = IN_W + 1;

   if (IN_W < 4 || IN_W > 40) begin : g_bad_in_w
      $error("sd_coef_mult_bank: IN_W out of range 4..40");
   end
   if (GRD < 3 || GRD > 12) begin : g_bad_grd
      $error("sd_coef_mult_bank: GRD out of range 3..12");
   end

   logic signed [IW-1:0] xe;
   logic signed [IW-1:0] term [NUM_TERMS];
   logic signed [IW-1:0] pair [NUM_PAIRS];
   logic signed [IW-1:0] prod [NUM_PROD];
   logic signed [OW-1:0] yv   [NUM_PROD];

   // sign-extend and append fractional guard bits
   assign xe = {{HEADROOM{x_in[IN_W-1]}}, x_in, {GRD{1'b0}}};

   sdmb_shift_terms #(.IW(IW)) u_terms (
      .xe_i   (xe),
      .term_o (term),
      .pair_o (pair)
   );

   sdmb_product_net #(.IW(IW)) u_net (
      .term_i (term),
      .pair_i (pair),
      .prod_o (prod)
   );

   sdmb_out_stage #(
      .IW        (IW),
      .OW        (OW),
      .GRD       (GRD),
      .ROUND_OUT (ROUND_OUT),
      .REG_OUT   (REG_OUT)
   ) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .prod_i (prod),
      .y_o    (yv)
   );

   assign y0_o = yv[0];
   assign y1_o = yv[1];
   assign y2_o = yv[2];
   assign y3_o = yv[3];
endmodule

// File: rtl/sdmb_checker.sv
module sdmb_checker
   import sdmb_pkg::*;
#(
   parameter int IN_W      = 16,
   parameter bit ROUND_OUT = 1'b1,
   parameter bit REG_OUT   = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic signed [IN_W-1:0] x_in,
   input logic signed [IN_W:0]   y0_o,
   input logic signed [IN_W:0]   y1_o,
   input logic signed [IN_W:0]   y2_o,
   input logic signed [IN_W:0]   y3_o
);
   localparam longint TOL = ROUND_OUT ? (longint'(1) << KDEN_LOG2) : (longint'(2) << KDEN_LOG2);

   logic signed [IN_W-1:0] x_q;
   logic signed [IN_W-1:0] x_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) x_q <= '0;
      else        x_q <= x_in;
   end
   assign x_ref = REG_OUT ? x_q : x_in;

   function automatic bit near(longint y, longint x, longint k);
      longint d;
      d = (y << KDEN_LOG2) - x * k;
      if (d < 0) d = -d;
      return d <= TOL;
   endfunction

   assert_near_y0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      near(longint'(y0_o), longint'(x_ref), longint'(KNUM[0])));
   assert_near_y1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      near(longint'(y1_o), longint'(x_ref), longint'(KNUM[1])));
   assert_near_y2_R8: assert property (@(posedge clk) disable iff (!rst_n)
      near(longint'(y2_o), longint'(x_ref), longint'(KNUM[2])));
   assert_near_y3_R8: assert property (@(posedge clk) disable iff (!rst_n)
      near(longint'(y3_o), longint'(x_ref), longint'(KNUM[3])));

   assert_sign_y0_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ref > 0) |-> (y0_o <= 0));
   assert_sign_y2_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ref < 0) |-> (y2_o <= 0));
   assert_sign_y3_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ref > 0) |-> (y3_o >= 0));
   assert_zero_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (x_ref == 0) |-> (y0_o == 0 && y1_o == 0 && y2_o == 0 && y3_o == 0));

   if (REG_OUT) begin : g_reg_chk
      assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (y0_o == 0 && y1_o == 0 && y2_o == 0 && y3_o == 0));
   end
endmodule

bind sd_coef_mult_bank sdmb_checker #(
   .IN_W      (IN_W),
   .ROUND_OUT (ROUND_OUT),
   .REG_OUT   (REG_OUT)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .x_in  (x_in),
   .y0_o  (y0_o),
   .y1_o  (y1_o),
   .y2_o  (y2_o),
   .y3_o  (y3_o)
);

// File: tb/sd_coef_mult_bank_bench.sv
`timescale 1ns/1ps
module sd_coef_mult_bank_bench;
   localparam int IN_W = 16;
   localparam int GRD  = 6;
   localparam int NV   = 12;

   localparam logic signed [IN_W-1:0] VEC [NV] = '{
      16'sd0, 16'sd1, -16'sd1, 16'sd2, 16'sd15, -16'sd16,
      16'sd255, -16'sd300, 16'sd4096, 16'sh7FFF, 16'sh8000, 16'sd12345};
   localparam longint KN [4]    = '{-4168, 7768, 28041, 16105};
   localparam real    NOM [4]   = '{-0.1294, 0.2241, 0.8365, 0.4830};
   localparam string  TAG [4]   = '{"R2", "R3", "R4", "R5"};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic signed [IN_W-1:0] x_in = '0;
   logic signed [IN_W:0] r0, r1, r2, r3, t0, t1, t2, t3;
   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   sd_coef_mult_bank #(.IN_W(IN_W), .GRD(GRD), .ROUND_OUT(1'b1), .REG_OUT(1'b1)) u_sd_coef_mult_bank (
      .clk(clk), .rst_n(rst_n), .x_in(x_in),
      .y0_o(r0), .y1_o(r1), .y2_o(r2), .y3_o(r3));

   sd_coef_mult_bank #(.IN_W(IN_W), .GRD(GRD), .ROUND_OUT(1'b0), .REG_OUT(1'b0)) u_sd_coef_mult_bank_trunc (
      .clk(clk), .rst_n(rst_n), .x_in(x_in),
      .y0_o(t0), .y1_o(t1), .y2_o(t2), .y3_o(t3));

   function automatic longint model(longint x, int idx, bit rnd);
      longint s, p;
      longint c [5];
      longint b [4];
      s = x * (longint'(1) << GRD);
      for (int k = 0; k < 5; k++) c[k] = s >>> (4 - k);
      b[0] = c[0] + c[3];
      b[1] = c[1] + c[3];
      b[2] = c[1] - c[3];
      b[3] = c[4] - c[1];
      case (idx)
         0:       p = -c[1] - (b[0] >>> 8);
         1:       p = c[2] + (b[2] >>> 5) - (b[1] >>> 9);
         2:       p = b[3] - (b[1] >>> 5) + (b[0] >>> 11);
         default: p = c[3] - (b[0] >>> 6) + (b[0] >>> 11);
      endcase
      if (rnd) p = p + (longint'(1) << (GRD - 1));
      return p >>> GRD;
   endfunction

   function automatic longint rsel(int i);
      case (i)
         0: return longint'(r0);
         1: return longint'(r1);
         2: return longint'(r2);
         default: return longint'(r3);
      endcase
   endfunction

   function automatic longint tsel(int i);
      case (i)
         0: return longint'(t0);
         1: return longint'(t1);
         2: return longint'(t2);
         default: return longint'(t3);
      endcase
   endfunction

   task automatic check(string tag, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic check_accuracy(int i, longint y, longint x, longint tol_lsb);
      longint d;
      real e, bound;
      d = (y << 15) - x * KN[i];
      if (d < 0) d = -d;
      check($sformatf("R8 realized y%0d x=%0d", i, x), (d <= (tol_lsb << 15)) ? 1 : 0, 1);
      e = real'(y) - real'(x) * NOM[i];
      if (e < 0.0) e = -e;
      bound = 0.021 * ((x < 0) ? -real'(x) : real'(x)) + 2.0;
      check($sformatf("R8 nominal y%0d x=%0d", i, x), (e <= bound) ? 1 : 0, 1);
   endtask

   task automatic check_sign(longint x);
      check($sformatf("R9 y0 sign x=%0d", x), ((x > 0 && rsel(0) > 0) || (x < 0 && rsel(0) < 0)) ? 1 : 0, 0);
      for (int i = 1; i < 4; i++)
         check($sformatf("R9 y%0d sign x=%0d", i, x),
               ((x > 0 && rsel(i) < 0) || (x < 0 && rsel(i) > 0)) ? 1 : 0, 0);
   endtask

   // drive at a falling edge, sample at the next falling edge
   task automatic apply_and_check(logic signed [IN_W-1:0] xv);
      longint x;
      x = longint'(xv);
      x_in = xv;
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
         check($sformatf("%s y%0d round x=%0d", TAG[i], i, x), rsel(i), model(x, i, 1'b1));
         check($sformatf("%s y%0d trunc (R6) x=%0d", TAG[i], i, x), tsel(i), model(x, i, 1'b0));
         check_accuracy(i, rsel(i), x, 1);
         check_accuracy(i, tsel(i), x, 2);
      end
      check_sign(x);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic signed [IN_W-1:0] prev;
      // R7: reset holds registered outputs at zero regardless of input
      x_in = 16'sd1234;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 4; i++) check($sformatf("R7 reset y%0d", i), rsel(i), 0);
      rst_n = 1'b1;

      // vector table, R2..R6, R8, R9
      for (int v = 0; v < NV; v++) apply_and_check(VEC[v]);

      // R9 zero input gives zero outputs
      apply_and_check(16'sd0);
      for (int i = 0; i < 4; i++) check($sformatf("R9 zero y%0d", i), rsel(i), 0);

      // R1 full-scale negative input, hand values
      apply_and_check(16'sh8000);
      check("R1 y0 full scale", rsel(0), 4168);
      check("R1 y1 full scale", rsel(1), -7768);
      check("R1 y2 full scale", rsel(2), -28041);
      check("R1 y3 full scale", rsel(3), -16105);
      check("R1 y0 full scale trunc", tsel(0), 4168);
      check("R1 y3 full scale trunc", tsel(3), -16105);

      // R6 rounding versus truncation at x=1: P0=-8, P2=55, P3=32
      apply_and_check(16'sd1);
      check("R6 round y0 x=1", rsel(0), 0);
      check("R6 round y2 x=1", rsel(2), 1);
      check("R6 round y3 x=1", rsel(3), 1);
      check("R6 trunc y0 x=1", tsel(0), -1);
      check("R6 trunc y2 x=1", tsel(2), 0);

      // R7 latency: registered path lags one edge, combinational path does not
      prev = 16'sd1;
      x_in = 16'sd20000;
      #1;
      check("R7 reg holds before edge", rsel(2), model(longint'(prev), 2, 1'b1));
      check("R7 comb follows at once", tsel(2), model(20000, 2, 1'b0));
      @(negedge clk);
      check("R7 reg updates after edge", rsel(2), model(20000, 2, 1'b1));

      // R7 asynchronous reset mid-run
      #2 rst_n = 1'b0;
      #1;
      for (int i = 0; i < 4; i++) check($sformatf("R7 async reset y%0d", i), rsel(i), 0);
      @(negedge clk);
      for (int i = 0; i < 4; i++) check($sformatf("R7 reset held y%0d", i), rsel(i), 0);
      rst_n = 1'b1;

      // random inputs
      for (int n = 0; n < 300; n++) apply_and_check(IN_W'($urandom));

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule